// File: doc/BRIEF.md
# Chroma 8x8 DC Intra Predictor

The block builds the DC intra prediction for one 8x8 chroma block. It takes eight reconstructed samples from the row above the block, eight from the column to its left, and one availability flag for each of those two edges. It splits the block into four 4x4 quadrants. Each quadrant gets its own flat value, and each quadrant picks its averaging source from its position and from which edges are present. When neither edge is present, every sample takes the mid-grey value.

A one-cycle `start` pulse captures the neighbours and the flags. The block then streams the prediction, one row of eight samples per cycle, on eight consecutive cycles. Each row carries its row number. `done` marks the last row. The caller must hold neither the neighbours nor the flags after the start cycle.

Top module: `chroma_dc_pred`

## Requirements
- R1: After reset, and whenever no row is being emitted, `row_valid` and `done` are low and `row_data` is zero.
- R2: A `start` accepted while idle gives row 0 in the next cycle. Rows 1 to 7 follow on the seven cycles after that, with `row_idx` equal to the row number, and `row_valid` then drops.
- R3: `done` is high only together with row 7, for exactly one cycle per block.
- R4: A `start` pulse that arrives while `row_valid` is high is ignored. The current block keeps its row sequence and its sample values.
- R5: Neighbours and flags are captured in the cycle `start` is accepted. Changing them afterwards has no effect on the block being emitted.
- R6: With both edges present (`avail_up`=1, `avail_left`=1), the quadrant values are set as follows, where U0 is the sum of above samples 0-3, U1 the sum of above 4-7, L0 the sum of left 0-3 and L1 the sum of left 4-7:
  - top-left is (U0+L0+4)>>3
  - bottom-right is (U1+L1+4)>>3
  - top-right is (U1+2)>>2
  - bottom-left is (L1+2)>>2
- R7: With only the above edge present, columns 0-3 take (U0+2)>>2 and columns 4-7 take (U1+2)>>2, in every row.
- R8: With only the left edge present, rows 0-3 take (L0+2)>>2 and rows 4-7 take (L1+2)>>2, across the whole row.
- R9: With neither edge present, every sample is 0x80.
- R10: Sample k of `above` sits in bits [8k+7:8k], and row k of `left` sits in bits [8k+7:8k]. Column c of `row_data` sits in bits [8c+7:8c].
- R11: Within one block, rows 0-3 are identical and rows 4-7 are identical. The quadrant boundaries are at row 4 and column 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the neighbours and flags, and begin a block |
| avail_up | input | 1 | Above row is present |
| avail_left | input | 1 | Left column is present |
| above | input | 64 | Eight above samples, sample 0 in the low byte |
| left | input | 64 | Eight left samples, row 0 in the low byte |
| row_valid | output | 1 | A prediction row is on `row_data` |
| row_idx | output | 3 | Number of the row on `row_data` |
| row_data | output | 64 | Eight predicted samples, column 0 in the low byte |
| done | output | 1 | High together with the last row |

## Verification
Each of the four availability combinations is driven with random neighbours. Random neighbours make the four partial sums differ, so a quadrant that reads the wrong half or the wrong edge shows up in a single row. All-0xFF neighbours test rounding and width at the largest sums, and all-zero neighbours test the low end. Neighbours that are uniform within each half give an exact value for every quadrant, which separates the position-dependent choice under both-available from the simpler single-edge layouts. Inputs that change, and extra start pulses sent in the middle of a block, tell a design that captures its inputs once apart from one that reads them live or restarts.

// File: rtl/chroma_dc_pred.sv
module chroma_dc_pred #(
  parameter int SW  = 8,
  parameter int BLK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              avail_up,
  input  logic              avail_left,
  input  logic [BLK*SW-1:0] above,
  input  logic [BLK*SW-1:0] left,
  output logic              row_valid,
  output logic [$clog2(BLK)-1:0] row_idx,
  output logic [BLK*SW-1:0] row_data,
  output logic              done
);
  localparam int HALF = BLK / 2;
  localparam int SH   = $clog2(HALF);
  localparam int PSW  = SW + SH;
  localparam int CW   = $clog2(BLK);
  localparam logic [SW-1:0] MID = SW'(1 << (SW - 1));

  function automatic logic [PSW-1:0] half_sum(input logic [BLK*SW-1:0] v, input int base);
    logic [PSW-1:0] s;
    s = '0;
    for (int i = 0; i < HALF; i++) s = s + PSW'(v[(base + i)*SW +: SW]);
    return s;
  endfunction

  function automatic logic [SW-1:0] avg1(input logic [PSW-1:0] s);
    logic [PSW:0] t;
    t = {1'b0, s} + (PSW+1)'(HALF / 2);
    return SW'(t >> SH);
  endfunction

  function automatic logic [SW-1:0] avg2(input logic [PSW-1:0] a, input logic [PSW-1:0] b);
    logic [PSW:0] t;
    t = {1'b0, a} + {1'b0, b} + (PSW+1)'(HALF);
    return SW'(t >> (SH + 1));
  endfunction

  logic [PSW-1:0] u0, u1, l0, l1;
  assign u0 = half_sum(above, 0);
  assign u1 = half_sum(above, HALF);
  assign l0 = half_sum(left, 0);
  assign l1 = half_sum(left, HALF);

  // quadrant index {bottom, right}: 0 tl, 1 tr, 2 bl, 3 br
  logic [SW-1:0] dc_nxt [4];
  logic [SW-1:0] dc_q   [4];

  always_comb begin
    case ({avail_up, avail_left})
      2'b11: begin
        dc_nxt[0] = avg2(u0, l0);
        dc_nxt[1] = avg1(u1);
        dc_nxt[2] = avg1(l1);
        dc_nxt[3] = avg2(u1, l1);
      end
      2'b10: begin
        dc_nxt[0] = avg1(u0);
        dc_nxt[1] = avg1(u1);
        dc_nxt[2] = avg1(u0);
        dc_nxt[3] = avg1(u1);
      end
      2'b01: begin
        dc_nxt[0] = avg1(l0);
        dc_nxt[1] = avg1(l0);
        dc_nxt[2] = avg1(l1);
        dc_nxt[3] = avg1(l1);
      end
      default: begin
        dc_nxt[0] = MID;
        dc_nxt[1] = MID;
        dc_nxt[2] = MID;
        dc_nxt[3] = MID;
      end
    endcase
  end

  logic          busy;
  logic [CW-1:0] row_cnt;
  logic          accept;
  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      row_cnt <= '0;
      for (int q = 0; q < 4; q++) dc_q[q] <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      row_cnt <= '0;
      for (int q = 0; q < 4; q++) dc_q[q] <= dc_nxt[q];
    end else if (busy) begin
      row_cnt <= row_cnt + 1'b1;
      if (row_cnt == CW'(BLK - 1)) busy <= 1'b0;
    end
  end

  assign row_valid = busy;
  assign row_idx   = row_cnt;
  assign done      = busy && (row_cnt == CW'(BLK - 1));

  for (genvar c = 0; c < BLK; c++) begin : g_col
    localparam bit RIGHT = (c >= HALF);
    assign row_data[c*SW +: SW] = busy ? dc_q[{row_cnt[CW-1], RIGHT}] : '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !row_valid |-> (!done && row_data == '0));
  p_first_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !row_valid) |=> (row_valid && row_idx == '0));
  p_next_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !done) |=> (row_valid && row_idx == $past(row_idx) + 1'b1));
  p_done_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (row_valid && row_idx == CW'(BLK - 1)));
  p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !row_valid);
  p_half_flat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_idx != '0 && row_idx != CW'(HALF)) |-> $stable(row_data));
endmodule

// File: tb/test_chroma_dc_pred.sv
module test_chroma_dc_pred;
  logic clk = 0, rst_n = 0, start = 0, avail_up = 0, avail_left = 0;
  logic [63:0] above = '0, left = '0;
  logic row_valid, done;
  logic [2:0] row_idx;
  logic [63:0] row_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  chroma_dc_pred i_chroma_dc_pred (
    .clk(clk), .rst_n(rst_n), .start(start), .avail_up(avail_up),
    .avail_left(avail_left), .above(above), .left(left),
    .row_valid(row_valid), .row_idx(row_idx), .row_data(row_data), .done(done));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int hsum(input logic [63:0] v, input int base);
    int s = 0;
    for (int i = 0; i < 4; i++) s += int'(v[8*(base+i) +: 8]);
    return s;
  endfunction

  function automatic logic [63:0] exp_row(input bit au, input bit al,
      input logic [63:0] up, input logic [63:0] lf, input int r);
    logic [63:0] v;
    int su, sl, x;
    for (int c = 0; c < 8; c++) begin
      su = hsum(up, (c < 4) ? 0 : 4);
      sl = hsum(lf, (r < 4) ? 0 : 4);
      if (au && al) begin
        if (r < 4 && c >= 4)      x = (su + 2) / 4;
        else if (r >= 4 && c < 4) x = (sl + 2) / 4;
        else                      x = (su + sl + 4) / 8;
      end else if (au) x = (su + 2) / 4;
      else if (al)     x = (sl + 2) / 4;
      else             x = 128;
      v[8*c +: 8] = 8'(x);
    end
    return v;
  endfunction

  task automatic run_block(input bit au, input bit al, input logic [63:0] up,
      input logic [63:0] lf, input bit disturb, input string req);
    @(negedge clk);
    avail_up = au; avail_left = al; above = up; left = lf; start = 1;
    @(negedge clk);
    start = 0;
    for (int r = 0; r < 8; r++) begin
      if (r > 0) @(negedge clk);
      chk("R2 row_valid", 64'(row_valid), 64'd1);
      chk("R2 row_idx", 64'(row_idx), 64'(r));
      chk("R3 done", 64'(done), 64'(r == 7));
      chk(req, row_data, exp_row(au, al, up, lf, r));
      if (disturb && (r == 2 || r == 5)) begin
        above = {$urandom, $urandom}; left = {$urandom, $urandom};
        avail_up = ~au; avail_left = ~al; start = 1;
      end else if (disturb) begin
        start = 0;
        above = {$urandom, $urandom};
      end
    end
    start = 0;
    @(negedge clk);
    chk("R2 end row_valid", 64'(row_valid), 64'd0);
    chk("R1 idle done", 64'(done), 64'd0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk("R1 reset row_valid", 64'(row_valid), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    chk("R1 reset row_data", row_data, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle row_data", row_data, 64'd0);
    // R6 R10 R11 halves uniform: exact quadrant values
    run_block(1, 1, 64'h4040_4040_1010_1010, 64'h8080_8080_2020_2020, 0, "R6 directed");
    chk("R6 top-left", 64'(exp_row(1,1,64'h4040_4040_1010_1010,64'h8080_8080_2020_2020,0) & 64'hff), 64'h18);
    run_block(1, 1, '1, '1, 0, "R6 max");
    run_block(1, 1, '0, '0, 0, "R6 zero");
    run_block(1, 0, 64'h0102_0304_F0E0_D0C0, '1, 0, "R7 directed");
    run_block(0, 1, '1, 64'h0102_0304_F0E0_D0C0, 0, "R8 directed");
    run_block(0, 0, {$urandom, $urandom}, {$urandom, $urandom}, 0, "R9 none");
    // R4 R5 start and input changes mid-block
    run_block(1, 1, {$urandom, $urandom}, {$urandom, $urandom}, 1, "R4 R5 disturb");
    run_block(0, 1, {$urandom, $urandom}, {$urandom, $urandom}, 1, "R4 R5 disturb left");
    for (int n = 0; n < 120; n++) begin
      logic [1:0] m;
      m = 2'($urandom);
      case (m)
        2'b11:   run_block(1, 1, {$urandom, $urandom}, {$urandom, $urandom}, n[0], "R6 random");
        2'b10:   run_block(1, 0, {$urandom, $urandom}, {$urandom, $urandom}, n[0], "R7 random");
        2'b01:   run_block(0, 1, {$urandom, $urandom}, {$urandom, $urandom}, n[0], "R8 random");
        default: run_block(0, 0, {$urandom, $urandom}, {$urandom, $urandom}, n[0], "R9 random");
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule